// File: doc/BRIEF.md
# Serial Control Register Port

A slave-side serial port that lets an external host set up and inspect the control registers of a mixed-signal front end. Each transaction is a 12-bit frame carried on one serial data input and clocked by the host's serial clock. It is framed by an active-low select. The first bit chooses the direction. The next three bits name one of eight register slots. The last eight bits carry the data word.

A write frame updates one of five control registers, and the updated value appears on a flat parallel output that drives the analog side. A read frame returns a register's contents on a separate serial output. Slot 7 is a read-only status word whose only live bit is a clip flag fed from the analog side. Slots 5 and 6 hold nothing. Bits that a register does not implement are tied to zero.

Top module: `ctl_serial_port`

## Requirements
- R1: A frame starts at the first falling edge of `sclk_i` with `sel_ni` low. Its first bit selects the direction (1 = read, 0 = write). The next three bits form the slot address, most significant bit first.
- R2: Input bits are sampled on falling edges of `sclk_i`. Frame bits 5 to 12 are the data word, least significant bit first. A write frame updates the addressed control register at the falling edge that samples the 12th bit. Register n sits on `ctrl_o[8n+7:8n]`.
- R3: In a read frame, `sdo_o` changes on rising edges. Data bit j is driven on the rising edge that follows the sampling of frame bit 4+j, so bit 0 comes first. Outside the eight data bits of a read frame, `sdo_o` is 0.
- R4: While `sel_ni` is high at a falling edge, the bit count is cleared. A frame that ends before its 12th bit changes no register.
- R5: Bits past the 12th, sent while `sel_ni` stays low, are ignored.
- R6: While `rst_ni` is low, each control register is forced, without waiting for a clock, to its default value `RST_VAL` masked by `IMPL_MASK`. The default value is zero.
- R7: Only bits set in `IMPL_MASK` are implemented. By default these are FF, 7F, 07, 7F and 7F for registers 0 to 4. Other bits read back as zero and cannot be set.
- R8: Slots 5 and 6 are unused. Writes to them are ignored, and reads from them return zero.
- R9: Slot 7 is read-only. Its bit 0 is `clip_i` after two rising edges of synchronisation, and its other bits are zero. Writes to slot 7 are ignored.
- R10: A read frame changes no register. The read word is captured on the rising edge that follows the address, so later changes of the status do not alter a read already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock from the host |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data from the host |
| clip_i | input | 1 | Clip flag from the analog side |
| sdo_o | output | 1 | Serial read data to the host |
| ctrl_o | output | 40 | Control registers 0 to 4, register n at bits 8n+7:8n |

## Verification
The status path and the read path can act in the same cycle. The clip flag may pass through its synchroniser on the same rising edge at which a status read captures its word, or while that word is being shifted out. The bench provokes this by toggling `clip_i` in the middle of a slot 7 read. The toggle falls after the capture edge, so the expected bit is the flag's value before the toggle. Randomised frames mix reads, writes, unused and read-only slots, with occasional clip changes, and every outcome is compared against a bench-side register model.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int HDR_LEN   = 1 + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_LEN);
endpackage

// File: rtl/csp_frame_rx.sv
module csp_frame_rx
  import ctl_serial_pkg::*;
(
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      addr_q <= '0;
      dat_q  <= '0;
    end else if (sel_ni) begin
      cnt_q <= '0;
    end else begin
      if (cnt_q < CNT_END) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) dir_q <= sdi_i;
      else if (cnt_q < CNT_HDR) addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
      else if (cnt_q < CNT_END) dat_q <= {sdi_i, dat_q[DATA_W-1:1]};
    end
  end

  // commit strobe consumed on the same falling edge as the last bit
  assign wr_en_o   = !sel_ni && !dir_q && (cnt_q == CNT_LAST);
  assign wr_data_o = {sdi_i, dat_q[DATA_W-1:1]};
  assign cnt_o     = cnt_q;
  assign dir_o     = dir_q;
  assign addr_o    = addr_q;
endmodule

// File: rtl/csp_reg_bank.sv
module csp_reg_bank
  import ctl_serial_pkg::*;
#(
  parameter int                         NUM_CTRL  = 5,
  parameter logic [NUM_CTRL*DATA_W-1:0] IMPL_MASK = '1,
  parameter logic [NUM_CTRL*DATA_W-1:0] RST_VAL   = '0
) (
  input  logic                         sclk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [NUM_CTRL*DATA_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MSK = IMPL_MASK[g*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] DEF = RST_VAL[g*DATA_W +: DATA_W] & MSK;
    logic [DATA_W-1:0] r_q;
    always_ff @(negedge sclk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= DEF;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g)) r_q <= wr_data_i & MSK;
    end
    assign regs_o[g*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/csp_rd_tx.sv
module csp_rd_tx
  import ctl_serial_pkg::*;
#(
  parameter int NUM_CTRL    = 5,
  parameter int STATUS_ADDR = 7
) (
  input  logic                       sclk_i,
  input  logic                       rst_ni,
  input  logic                       sel_ni,
  input  logic                       clip_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic                       dir_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_CTRL*DATA_W-1:0] regs_i,
  output logic                       sdo_o
);
  logic [1:0]        clip_sync_q;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] sh_q;
  logic              sdo_q;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr_i == ADDR_W'(i)) rd_word = regs_i[i*DATA_W +: DATA_W];
    if (addr_i == ADDR_W'(STATUS_ADDR)) rd_word = DATA_W'(clip_sync_q[1]);
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clip_sync_q <= '0;
      sh_q        <= '0;
      sdo_q       <= 1'b0;
    end else begin
      clip_sync_q <= {clip_sync_q[0], clip_i};
      if (!sel_ni && dir_i && cnt_i == CNT_HDR) begin
        sdo_q <= rd_word[0];
        sh_q  <= rd_word >> 1;
      end else if (!sel_ni && dir_i && cnt_i > CNT_HDR && cnt_i < CNT_END) begin
        sdo_q <= sh_q[0];
        sh_q  <= sh_q >> 1;
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_serial_pkg::*;
#(
  parameter int                         NUM_CTRL    = 5,
  parameter int                         STATUS_ADDR = 7,
  parameter logic [NUM_CTRL*DATA_W-1:0] IMPL_MASK   = 40'h7F_7F_07_7F_FF,
  parameter logic [NUM_CTRL*DATA_W-1:0] RST_VAL     = '0
) (
  input  logic                       sclk_i,
  input  logic                       rst_ni,
  input  logic                       sel_ni,
  input  logic                       sdi_i,
  input  logic                       clip_i,
  output logic                       sdo_o,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;

  csp_frame_rx u_rx (
    .sclk_i, .rst_ni, .sel_ni, .sdi_i,
    .cnt_o(cnt_q), .dir_o(dir_q), .addr_o(addr_q),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  csp_reg_bank #(.NUM_CTRL(NUM_CTRL), .IMPL_MASK(IMPL_MASK), .RST_VAL(RST_VAL)) u_bank (
    .sclk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(addr_q),
    .wr_data_i(wr_data), .regs_o(ctrl_o)
  );

  csp_rd_tx #(.NUM_CTRL(NUM_CTRL), .STATUS_ADDR(STATUS_ADDR)) u_tx (
    .sclk_i, .rst_ni, .sel_ni, .clip_i,
    .cnt_i(cnt_q), .dir_i(dir_q), .addr_i(addr_q),
    .regs_i(ctrl_o), .sdo_o
  );
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk
  import ctl_serial_pkg::*;
#(
  parameter int                         NUM_CTRL  = 5,
  parameter logic [NUM_CTRL*DATA_W-1:0] IMPL_MASK = '1
) (
  input logic                       sclk_i,
  input logic                       rst_ni,
  input logic                       sel_ni,
  input logic                       sdo_o,
  input logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
  input logic [CNT_W-1:0]           cnt_q,
  input logic                       dir_q
);
  AST_SDO_IDLE_SEL: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    $past(sel_ni) |-> !sdo_o); // R3
  AST_SDO_ONLY_READ: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !$past(dir_q) |-> !sdo_o); // R3
  AST_CNT_BOUND: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END); // R5
  AST_WRITE_AT_LAST: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> ($past(cnt_q) == CNT_LAST && !$past(dir_q) && !$past(sel_ni))); // R2
  AST_READ_NO_CHANGE: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (dir_q && !sel_ni && cnt_q != '0) |=> $stable(ctrl_o)); // R10
  AST_MASKED_ZERO: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (ctrl_o & ~IMPL_MASK) == '0); // R7
endmodule

bind ctl_serial_port ctl_serial_port_chk #(.NUM_CTRL(NUM_CTRL), .IMPL_MASK(IMPL_MASK)) u_chk (
  .sclk_i(sclk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .sdo_o(sdo_o),
  .ctrl_o(ctrl_o), .cnt_q(cnt_q), .dir_q(dir_q)
);

// File: tb/ctl_serial_port_tb_top.sv
`timescale 1ns/1ps
module ctl_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, sel_ni = 1'b1, sdi = 1'b0, clip = 1'b0;
  logic sdo;
  logic [39:0] ctrl;
  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_q [5];
  logic clip_ref = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_serial_port dut_i (.sclk_i(clk), .rst_ni, .sel_ni, .sdi_i(sdi),
                         .clip_i(clip), .sdo_o(sdo), .ctrl_o(ctrl));

  function automatic logic [7:0] msk(int a);
    case (a) 0: return 8'hFF; 2: return 8'h07; default: return 8'h7F; endcase
  endfunction
  function automatic logic [39:0] packed_ref();
    logic [39:0] v;
    for (int i = 0; i < 5; i++) v[i*8 +: 8] = ref_q[i];
    return v;
  endfunction
  function automatic logic [7:0] exp_rd(int a);
    if (a < 5) return ref_q[a];
    if (a == 7) return {7'b0, clip_ref};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // nbits frame bits; read word and whether sdo was ever high outside the data bits
  task automatic frame(input bit rd, input logic [2:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] q, output bit stray);
    q = '0; stray = 0;
    for (int k = 0; k < nbits; k++) begin
      @(posedge clk); #1;
      if (!(rd && k >= 4 && k < 12) && sdo) stray = 1;
      sel_ni = 1'b0;
      if (k == 0) sdi = rd;
      else if (k < 4) sdi = a[3-k];
      else if (k < 12) sdi = d[k-4];
      else sdi = 1'($urandom);
      if (k >= 4 && k < 12) q[k-4] = sdo;
    end
    @(posedge clk); #1;
    if (sdo) stray = 1;
    sel_ni = 1'b1; sdi = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string req);
    logic [7:0] q; bit s;
    frame(1'b0, 3'(a), d, 12, q, s);
    if (a < 5) ref_q[a] = d & msk(a);
    chk(req, ctrl, packed_ref());
  endtask
  task automatic rd(input int a, input string req);
    logic [7:0] q; bit s;
    frame(1'b1, 3'(a), 8'h00, 12, q, s);
    chk(req, q, exp_rd(a));
  endtask
  task automatic set_clip(input logic v);
    clip = v; clip_ref = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    logic [7:0] q; bit s;
    for (int i = 0; i < 5; i++) ref_q[i] = 8'h00;
    #1; chk("R6 reset value", ctrl, 40'h0);
    #10 rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    // R1/R2 direction and LSB-first data, bit order visible through asymmetric patterns
    wr(0, 8'h01, "R2 write lsb");
    wr(0, 8'hA5, "R1 write reg0");
    wr(3, 8'h96, "R1 address msb first");
    rd(3, "R3 read reg3");
    rd(0, "R3 read reg0");
    frame(1'b1, 3'd0, 8'h00, 12, q, s);
    chk("R3 sdo idle outside data", s, 1'b0);
    // R7 masked bits
    wr(2, 8'hFF, "R7 mask reg2");
    rd(2, "R7 read reg2");
    wr(1, 8'hFF, "R7 mask reg1");
    // R8 unused slots
    wr(5, 8'h3C, "R8 write slot5 ignored");
    rd(5, "R8 read slot5");
    wr(6, 8'hFF, "R8 write slot6 ignored");
    rd(6, "R8 read slot6");
    // R9 status
    set_clip(1'b1);
    rd(7, "R9 clip set");
    wr(7, 8'hFF, "R9 write status ignored");
    rd(7, "R9 status after write");
    set_clip(1'b0);
    rd(7, "R9 clip clear");
    // R4 short frame
    frame(1'b0, 3'd4, 8'h55, 11, q, s);
    chk("R4 short frame no write", ctrl, packed_ref());
    wr(4, 8'h12, "R4 full frame after abort");
    // R5 trailing bits
    frame(1'b0, 3'd1, 8'h2B, 15, q, s);
    ref_q[1] = 8'h2B;
    chk("R5 trailing bits ignored", ctrl, packed_ref());
    // R10 read leaves registers; status captured before mid-read toggle
    frame(1'b1, 3'd4, 8'hFF, 12, q, s);
    chk("R10 read no change", ctrl, packed_ref());
    set_clip(1'b1);
    fork
      frame(1'b1, 3'd7, 8'h00, 12, q, s);
      begin repeat (7) @(posedge clk); #1 clip = 1'b0; end
    join
    chk("R10 status snapshot", q, 8'h01);
    clip_ref = 1'b0; repeat (3) @(posedge clk);
    rd(7, "R10 status after toggle");
    // random mix
    void'($urandom(32'h5eed_0042));
    for (int n = 0; n < 150; n++) begin
      int a = int'($urandom_range(7, 0));
      if ($urandom_range(9, 0) == 0) set_clip(1'($urandom));
      if ($urandom_range(1, 0) == 1) rd(a, "R1 random read");
      else wr(a, 8'($urandom), "R2 random write");
    end
    // R6 asynchronous reset mid-operation
    wr(0, 8'h77, "R2 pre-reset write");
    #1 rst_ni = 1'b0; #1;
    for (int i = 0; i < 5; i++) ref_q[i] = 8'h00;
    chk("R6 async reset", ctrl, 40'h0);
    #5 rst_ni = 1'b1;
    rd(0, "R6 read after reset");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule